// File: doc/BRIEF.md
# Microstep Sequencer with Fetch Jump

This block sequences the control steps of a small 8-bit teaching processor. A four-bit step counter runs through sixteen states, Q0 to Q15. Each enabled clock moves it forward one state, and it wraps from Q15 back to Q0. When the control logic raises the next-fetch input, the step jumps to Q3, the fetch step, instead of counting on.

Around the counter sit purely combinational outputs:
- a one-hot step word for a display, in which the two bytes are swapped;
- a sixteen-entry branch-condition vector built from the N, Z, V and C flags;
- a flag that marks execution of an externally handled opcode;
- a packed status byte carrying the opcode flags and the condition flags.

A run-to-fetch request clocks the counter by itself until it reaches Q3. It always takes at least one step.

Top module: `ustep_seq`

## Requirements
- R1: A synchronous active-high reset sets the step to Q0 and clears busy. After reset, step_word reads 16'h0100.
- R2: On a rising edge where a step occurs and next_fetch is high, the step becomes Q3.
- R3: On a rising edge where a step occurs and next_fetch is low, the step increments by one, and Q15 wraps to Q0.
- R4: With step_en low and no run in progress, the step holds and next_fetch has no effect.
- R5: step_word is one-hot. Step Qk sets bit k+8 for k below 8, and bit k-8 for k of 8 or more.
- R6: ext_op is high only when the step index is above 3 and ir is 8'h03, 8'h04, 8'hDF or 8'hEF.
- R7: The flags are read from cc as N = cc[3], Z = cc[2], V = cc[1] and C = cc[0]. cond_vec is built from them as follows:
  - bits 0 and 1 are the constants 1 and 0;
  - bits 2 to 9 are Z, !Z, N, !N, V, !V, C and !C;
  - bits 10 and 11 are C|V and its complement;
  - bits 12 and 13 are N^V and its complement;
  - bits 14 and 15 are (N^V)|Z and its complement.
- R8: The status byte packs the opcode flags and the condition flags:
  - status[3:0] is 1, 2, 4 or 8 for ir equal to 8'h03, 8'h04, 8'hDF or 8'hEF respectively, and 0 for any other value;
  - status[4] is C, status[5] is V, status[6] is N and status[7] is Z.
- R9: A run_req pulse while idle performs a step on that edge. busy is then high until the edge on which the step lands on Q3. From Q3 a run takes exactly 16 steps.
- R10: A run_req while busy is high is ignored. If next_fetch is high during a run, the run ends on that edge at Q3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the step on this edge |
| next_fetch | input | 1 | Jump to Q3 instead of incrementing |
| run_req | input | 1 | One-cycle request to step until Q3 |
| ir | input | 8 | Instruction register value |
| cc | input | 4 | Condition codes {N,Z,V,C} |
| step_idx | output | 4 | Current step number |
| step_word | output | 16 | Byte-swapped one-hot step word |
| cond_vec | output | 16 | Branch-condition vector |
| ext_op | output | 1 | External opcode in execution |
| status | output | 8 | Opcode flags and condition flags |
| busy | output | 1 | Run-to-fetch in progress |

## Verification
A corrupted step counter shows on step_idx and step_word right after the edge that wrote it. It also shifts ext_op between steps Q3 and Q4. A wrong busy state shows as a run-to-fetch that ends away from Q3, or that takes a number of edges other than the expected count. Decode faults in the condition vector or the status byte show combinationally, as soon as ir or cc changes.

// File: rtl/ustep_seq.sv
module ustep_seq #(
  parameter int STEPS = 16,
  parameter int FETCH_STEP = 3,
  localparam int SW = $clog2(STEPS),
  localparam int HALF = STEPS / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          next_fetch,
  input  logic          run_req,
  input  logic [7:0]    ir,
  input  logic [3:0]    cc,
  output logic [SW-1:0] step_idx,
  output logic [STEPS-1:0] step_word,
  output logic [15:0]   cond_vec,
  output logic          ext_op,
  output logic [7:0]    status,
  output logic          busy
);
  localparam logic [SW-1:0] FETCH = SW'(FETCH_STEP);
  localparam logic [SW-1:0] LAST  = SW'(STEPS - 1);

  logic [SW-1:0] q, q_nx;
  logic          adv;
  logic          fn, fz, fv, fc;

  assign adv  = step_en | busy | run_req;
  assign q_nx = next_fetch ? FETCH : (q == LAST) ? '0 : q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      busy <= 1'b0;
    end else if (adv) begin
      q <= q_nx;
      if (busy | run_req) busy <= (q_nx != FETCH);
    end
  end

  assign step_idx = q;

  genvar k;
  generate
    for (k = 0; k < STEPS; k++) begin : g_word
      localparam int SLOT = (k < HALF) ? k + HALF : k - HALF;
      assign step_word[SLOT] = (q == SW'(k));
    end
  endgenerate

  assign {fn, fz, fv, fc} = cc;

  assign cond_vec = {~((fn ^ fv) | fz), (fn ^ fv) | fz,
                     ~(fn ^ fv), fn ^ fv,
                     ~(fc | fv), fc | fv,
                     ~fc, fc, ~fv, fv, ~fn, fn, ~fz, fz,
                     1'b0, 1'b1};

  logic [3:0] op_hit;
  always_comb begin
    case (ir)
      8'h03:   op_hit = 4'b0001;
      8'h04:   op_hit = 4'b0010;
      8'hDF:   op_hit = 4'b0100;
      8'hEF:   op_hit = 4'b1000;
      default: op_hit = 4'b0000;
    endcase
  end

  assign ext_op = (q > FETCH) && (op_hit != 4'b0000);
  assign status = {fz, fn, fv, fc, op_hit};
endmodule

module ustep_seq_chk #(
  parameter int SW = 4,
  parameter int STEPS = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          step_en,
  input logic          next_fetch,
  input logic          run_req,
  input logic [SW-1:0] step_idx,
  input logic [STEPS-1:0] step_word,
  input logic          ext_op,
  input logic          busy
);
  a_r1_reset: assert property (@(posedge clk) rst |=> (step_idx == '0 && !busy));
  a_r2_jump: assert property (@(posedge clk) disable iff (rst)
    (step_en && next_fetch) |=> step_idx == SW'(3));
  a_r3_incr: assert property (@(posedge clk) disable iff (rst)
    (step_en && !next_fetch) |=> step_idx == SW'($past(step_idx) + 1'b1));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !busy && !run_req) |=> $stable(step_idx));
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(step_word) == 1);
  a_r6_ext_late: assert property (@(posedge clk) disable iff (rst)
    ext_op |-> step_idx > SW'(3));
  a_r9_end_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> step_idx == SW'(3));
  a_r10_run_moves: assert property (@(posedge clk) disable iff (rst)
    (busy && !next_fetch) |=> step_idx != $past(step_idx));
endmodule

bind ustep_seq ustep_seq_chk #(.SW(SW), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .next_fetch(next_fetch),
  .run_req(run_req), .step_idx(step_idx), .step_word(step_word),
  .ext_op(ext_op), .busy(busy));

// File: tb/sim_ustep_seq.sv
module sim_ustep_seq;
  logic clk = 0, rst = 1, step_en = 0, next_fetch = 0, run_req = 0;
  logic [7:0] ir = 0;
  logic [3:0] cc = 0;
  logic [3:0] step_idx;
  logic [15:0] step_word, cond_vec;
  logic ext_op, busy;
  logic [7:0] status;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ustep_seq u0 (.*);

  localparam logic [11:0] VEC [8] = '{
    {8'h03, 4'b0000}, {8'h04, 4'b1111}, {8'hDF, 4'b1010}, {8'hEF, 4'b0101},
    {8'h00, 4'b1000}, {8'hFF, 4'b0100}, {8'h30, 4'b0010}, {8'hDE, 4'b0001}};

  function automatic logic [15:0] exp_cond(input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    return {~((n^v)|z), (n^v)|z, ~(n^v), n^v, ~(c|v), c|v,
            ~c, c, ~v, v, ~n, n, ~z, z, 1'b0, 1'b1};
  endfunction

  function automatic logic [3:0] exp_op(input logic [7:0] i);
    return (i == 8'h03) ? 4'd1 : (i == 8'h04) ? 4'd2 :
           (i == 8'hDF) ? 4'd4 : (i == 8'hEF) ? 4'd8 : 4'd0;
  endfunction

  function automatic logic [15:0] exp_word(input int s);
    return 16'(1) << ((s < 8) ? s + 8 : s - 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    tick;
    rst = 0;
    chk("R1 step", step_idx, 0);
    chk("R1 word", step_word, 16'h0100);
    chk("R1 busy", busy, 0);

    for (int i = 0; i < 8; i++) begin
      {ir, cc} = VEC[i];
      #1;
      chk("R7 cond", cond_vec, exp_cond(cc));
      chk("R8 status", status, {cc[2], cc[3], cc[1], cc[0], exp_op(ir)});
      chk("R6 ext at Q0", ext_op, 0);
    end

    step_en = 1;
    for (int s = 1; s <= 17; s++) begin
      tick;
      chk("R3 incr/wrap", step_idx, s % 16);
      chk("R5 word", step_word, exp_word(s % 16));
    end
    while (step_idx != 9) tick;
    next_fetch = 1;
    tick;
    chk("R2 jump", step_idx, 3);
    tick;
    chk("R2 jump at Q3", step_idx, 3);
    step_en = 0;
    next_fetch = 0;
    tick;
    chk("R4 hold", step_idx, 3);
    next_fetch = 1;
    step_en = 1;
    tick;
    step_en = 0;
    next_fetch = 0;
    step_en = 1;
    tick;
    step_en = 0;
    chk("R4 setup Q4", step_idx, 4);
    next_fetch = 1;
    tick;
    tick;
    next_fetch = 0;
    chk("R4 next_fetch ignored", step_idx, 4);

    ir = 8'hDF;
    #1;
    chk("R6 ext at Q4", ext_op, 1);
    step_en = 1;
    next_fetch = 1;
    tick;
    step_en = 0;
    next_fetch = 0;
    chk("R6 ext at Q3", ext_op, 0);

    run_req = 1;
    tick;
    run_req = 0;
    n = 1;
    chk("R9 busy after req", busy, 1);
    chk("R9 first step", step_idx, 4);
    for (int k = 0; k < 40 && busy; k++) begin
      if (k == 5) run_req = 1;
      tick;
      run_req = 0;
      n++;
    end
    chk("R9 R10 run length", n, 16);
    chk("R9 ends Q3", step_idx, 3);
    tick;
    chk("R9 idle after run", step_idx, 3);

    run_req = 1;
    tick;
    run_req = 0;
    tick;
    tick;
    chk("R10 mid run", step_idx, 6);
    next_fetch = 1;
    tick;
    next_fetch = 0;
    chk("R10 fetch ends run", step_idx, 3);
    chk("R10 busy clear", busy, 0);

    while (step_idx != 2) begin
      step_en = 1;
      tick;
    end
    step_en = 0;
    run_req = 1;
    tick;
    run_req = 0;
    chk("R9 one-step run", step_idx, 3);
    chk("R9 one-step busy", busy, 0);

    run_req = 1;
    tick;
    run_req = 0;
    tick;
    rst = 1;
    tick;
    rst = 0;
    chk("R1 reset mid run step", step_idx, 0);
    chk("R1 reset mid run busy", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule